// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block is the digital half of a processor supervisor. It takes a supply-good flag from an external comparator, an active-low manual reset line, a watchdog kick line and a power-fail comparator flag. It drives a pair of complementary reset outputs, a watchdog-expired output and a power-fail output. The supply-good flag arrives already synchronized to the clock. The other comparator flag is passed straight through. All time-outs are counted in clock cycles and set by parameters.

Reset is raised at power-up, while the supply is bad, and while the debounced manual reset is held. It is then stretched by a fixed hold time after the last cause clears. The watchdog counts clock cycles between edges on the kick line. When it expires it pulls its own output low and holds it there until something clears the watchdog. An expiry never raises reset by itself. A system that wants the watchdog to reset the processor wires the watchdog output back to the manual reset input.

Top module: `rsv_supervisor`

## Requirements
- R1: Reset is asserted (rst_o = 1) while rst_ni is low, on the clock edge after supply_ok_i is sampled low, and on the clock edge after the debounced manual reset is seen low.
- R2: Once no reset cause is present, reset stays asserted for exactly RESET_HOLD_CYCLES further clock edges, then drops. The causes are rst_ni low, supply_ok_i low, and the filtered manual reset low. Any cause during the hold restarts the count. After rst_ni rises with no other cause, rst_o is 1 for RESET_HOLD_CYCLES-1 edges and 0 after the RESET_HOLD_CYCLES-th edge.
- R3: rst_no is always the exact complement of rst_o.
- R4: mr_ni passes through a two-flop synchronizer. Its filtered value changes only after the synchronized value has differed from it on DEBOUNCE_CYCLES consecutive clock edges. A shorter low pulse has no effect on rst_o.
- R5: kick_i passes through a two-flop synchronizer. Both its rising and its falling edges clear the watchdog counter, so regular toggling keeps wdt_no high.
- R6: After WDT_CYCLES consecutive clock edges with no clear, the watchdog expires. While the supply is good, wdt_no then stays 0 until the next clear.
- R7: The watchdog is held cleared while the filtered manual reset is low and while reset is asserted, so it cannot expire during a reset.
- R8: A watchdog expiry does not change rst_o or rst_no.
- R9: wdt_no is 0 in the same cycle that supply_ok_i is 0. It returns to 1 in the same cycle that supply_ok_i returns to 1, with no minimum low time.
- R10: pf_o equals pf_cmp_i combinationally at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on) |
| supply_ok_i | input | 1 | Synchronized supply-good flag from the comparator |
| mr_ni | input | 1 | Active-low manual reset request (asynchronous, bouncing) |
| kick_i | input | 1 | Watchdog kick line (asynchronous) |
| pf_cmp_i | input | 1 | Power-fail comparator flag |
| rst_no | output | 1 | Active-low reset output |
| rst_o | output | 1 | Active-high reset output |
| wdt_no | output | 1 | Watchdog output, low when expired or supply bad |
| pf_o | output | 1 | Power-fail output |

## Verification
The bench builds the supervisor with DEBOUNCE_CYCLES = 4, RESET_HOLD_CYCLES = 20 and WDT_CYCLES = 50. With these values a full power-up stretch, a watchdog expiry and its recovery, a rejected manual-reset glitch and a long manual reset all fit into a few hundred cycles. The settings also allow a randomized phase in which supply drops, kick edges and manual-reset pulses interleave with the hold and watchdog windows.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic [1:0] {
    RS_CAUSE   = 2'd0,
    RS_STRETCH = 2'd1,
    RS_IDLE    = 2'd2
  } rst_state_e;

  // Width for a counter that holds 0 .. n-1
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rsv_debounce.sv
module rsv_debounce #(
  parameter int unsigned CYCLES  = 4,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  import rsv_pkg::*;

  localparam int unsigned CW = cnt_w(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= RST_VAL;
      cnt_q  <= '0;
    end else if (d_i == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      filt_q <= d_i;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = filt_q;
endmodule

// File: rtl/rsv_reset_timer.sv
module rsv_reset_timer #(
  parameter int unsigned HOLD_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cause_i,
  output logic rst_active_o
);
  import rsv_pkg::*;

  localparam int unsigned CW = cnt_w(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  rst_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_STRETCH;
      cnt_q   <= '0;
    end else if (cause_i) begin
      state_q <= RS_CAUSE;
      cnt_q   <= '0;
    end else if (state_q != RS_IDLE) begin
      if (cnt_q == LAST) begin
        state_q <= RS_IDLE;
        cnt_q   <= '0;
      end else begin
        state_q <= RS_STRETCH;
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_active_o = (state_q != RS_IDLE);
endmodule

// File: rtl/rsv_watchdog.sv
module rsv_watchdog #(
  parameter int unsigned WDT_CYCLES = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic expired_o
);
  import rsv_pkg::*;

  localparam int unsigned CW = cnt_w(WDT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WDT_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (!exp_q) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        exp_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign expired_o = exp_q;
endmodule

// File: rtl/rsv_supervisor.sv
module rsv_supervisor #(
  parameter int unsigned DEBOUNCE_CYCLES   = 1_000_000,
  parameter int unsigned RESET_HOLD_CYCLES = 40_000_000,
  parameter int unsigned WDT_CYCLES        = 320_000_000,
  parameter int unsigned SYNC_STAGES       = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic mr_ni,
  input  logic kick_i,
  input  logic pf_cmp_i,
  output logic rst_no,
  output logic rst_o,
  output logic wdt_no,
  output logic pf_o
);
  logic mr_sync;
  logic mr_filt;
  logic kick_sync;
  logic kick_prev_q;
  logic kick_edge;
  logic rst_cause;
  logic rst_active;
  logic wdt_clear;
  logic wdt_expired;

  rsv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mr_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mr_ni),
    .q_o   (mr_sync)
  );

  rsv_debounce #(.CYCLES(DEBOUNCE_CYCLES), .RST_VAL(1'b1)) u_mr_deb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mr_sync),
    .q_o   (mr_filt)
  );

  rsv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_kick_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (kick_i),
    .q_o   (kick_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kick_prev_q <= 1'b0;
    else         kick_prev_q <= kick_sync;
  end

  // either polarity of kick counts as activity
  assign kick_edge = kick_sync ^ kick_prev_q;
  assign rst_cause = ~supply_ok_i | ~mr_filt;

  rsv_reset_timer #(.HOLD_CYCLES(RESET_HOLD_CYCLES)) u_rst_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cause_i     (rst_cause),
    .rst_active_o(rst_active)
  );

  assign wdt_clear = kick_edge | ~mr_filt | rst_active;

  rsv_watchdog #(.WDT_CYCLES(WDT_CYCLES)) u_wdt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (wdt_clear),
    .expired_o(wdt_expired)
  );

  assign rst_o  = rst_active;
  assign rst_no = ~rst_active;
  // no stretch on the watchdog output: supply loss gates it directly
  assign wdt_no = supply_ok_i & ~wdt_expired;
  assign pf_o   = pf_cmp_i;
endmodule

// File: rtl/rsv_supervisor_chk.sv
module rsv_supervisor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_ok_i,
  input logic pf_cmp_i,
  input logic rst_no,
  input logic rst_o,
  input logic wdt_no,
  input logic pf_o,
  input logic mr_filt,
  input logic wdt_clear,
  input logic wdt_expired
);
  p_rst_cmpl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o == !rst_no);

  p_supply_rst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> rst_o);

  p_mr_rst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mr_filt |=> rst_o);

  p_rst_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> ($past(supply_ok_i) && $past(mr_filt)));

  p_wdt_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_expired && !wdt_clear) |=> wdt_expired);

  p_wdt_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clear |=> !wdt_expired);

  p_wdt_no_rst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(wdt_no) && supply_ok_i) |-> !rst_o);

  p_wdt_supply_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |-> !wdt_no);

  p_pf_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_o == pf_cmp_i);
endmodule

bind rsv_supervisor rsv_supervisor_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .supply_ok_i(supply_ok_i),
  .pf_cmp_i   (pf_cmp_i),
  .rst_no     (rst_no),
  .rst_o      (rst_o),
  .wdt_no     (wdt_no),
  .pf_o       (pf_o),
  .mr_filt    (mr_filt),
  .wdt_clear  (wdt_clear),
  .wdt_expired(wdt_expired)
);

// File: tb/tb_rsv_supervisor.sv
`timescale 1ns/1ps
module tb_rsv_supervisor;
  localparam int DEB  = 4;
  localparam int HOLD = 20;
  localparam int WDT  = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic supply = 1'b1;
  logic mr = 1'b1;
  logic kick = 1'b0;
  logic pf = 1'b0;
  logic rst_no, rst_o, wdt_no, pf_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rsv_supervisor #(
    .DEBOUNCE_CYCLES  (DEB),
    .RESET_HOLD_CYCLES(HOLD),
    .WDT_CYCLES       (WDT)
  ) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .supply_ok_i(supply),
    .mr_ni      (mr),
    .kick_i     (kick),
    .pf_cmp_i   (pf),
    .rst_no     (rst_no),
    .rst_o      (rst_o),
    .wdt_no     (wdt_no),
    .pf_o       (pf_o)
  );

  // behavioural reference
  int m_mr1, m_mr2, m_filt, m_dcnt;
  int m_k1, m_k2, m_k3;
  int m_rst, m_quiet, m_wcnt, m_exp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mr1 = 1; m_mr2 = 1; m_filt = 1; m_dcnt = 0;
      m_k1 = 0; m_k2 = 0; m_k3 = 0;
      m_rst = 1; m_quiet = 0; m_wcnt = 0; m_exp = 0;
    end else begin
      bit clr, cause;
      clr   = (m_k2 != m_k3) || (m_filt == 0) || (m_rst == 1);
      cause = (supply == 1'b0) || (m_filt == 0);
      if (clr) begin
        m_wcnt = 0; m_exp = 0;
      end else if (m_exp == 0) begin
        m_wcnt++;
        if (m_wcnt == WDT) begin m_exp = 1; m_wcnt = 0; end
      end
      if (cause) begin
        m_rst = 1; m_quiet = 0;
      end else if (m_rst == 1) begin
        m_quiet++;
        if (m_quiet == HOLD) begin m_rst = 0; m_quiet = 0; end
      end
      if (m_mr2 == m_filt) m_dcnt = 0;
      else begin
        m_dcnt++;
        if (m_dcnt == DEB) begin m_filt = m_mr2; m_dcnt = 0; end
      end
      m_k3 = m_k2; m_k2 = m_k1; m_k1 = int'(kick);
      m_mr2 = m_mr1; m_mr1 = int'(mr);
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    check("R1/R2 rst_o", rst_o, logic'(m_rst));
    check("R3 rst_no", rst_no, ~rst_o);
    check("R6/R9 wdt_no", wdt_no, supply & (m_exp == 0));
    check("R10 pf_o", pf_o, pf);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      compare_model();
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    #1;
    check("R1 reset state", rst_o, 1'b1);
    check("R3 reset state", rst_no, 1'b0);
    check("R9 reset state wdt", wdt_no, 1'b1);
    check("R10 reset state pf", pf_o, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // power-up stretch
    tick(HOLD - 1);
    check("R2 still held", rst_o, 1'b1);
    tick(1);
    check("R2 released", rst_o, 1'b0);

    // regular kicking keeps the watchdog alive
    for (int i = 0; i < 20; i++) begin
      kick = ~kick;
      tick(10);
    end
    check("R5 kicked", wdt_no, 1'b1);

    // power-fail passthrough
    pf = 1'b1; #1;
    check("R10 pf high", pf_o, 1'b1);
    tick(2);
    pf = 1'b0; #1;
    check("R10 pf low", pf_o, 1'b0);

    // expiry
    tick(WDT + 10);
    check("R6 expired", wdt_no, 1'b0);
    check("R8 no reset", rst_o, 1'b0);
    tick(30);
    check("R6 stays low", wdt_no, 1'b0);
    kick = ~kick;
    tick(4);
    check("R5 edge clears", wdt_no, 1'b1);

    // short glitch on manual reset
    mr = 1'b0;
    tick(2);
    mr = 1'b1;
    tick(8);
    check("R4 glitch ignored", rst_o, 1'b0);

    // long manual reset with no kicks
    mr = 1'b0;
    tick(WDT + 20);
    check("R1 manual reset", rst_o, 1'b1);
    check("R7 held clear", wdt_no, 1'b1);
    mr = 1'b1;
    tick(HOLD + 10);
    check("R2 manual release", rst_o, 1'b0);

    // supply drop
    supply = 1'b0; #1;
    check("R9 wdt low now", wdt_no, 1'b0);
    tick(1);
    check("R1 supply reset", rst_o, 1'b1);
    tick(5);
    supply = 1'b1; #1;
    check("R9 wdt high now", wdt_no, 1'b1);
    tick(HOLD + 5);
    check("R2 supply release", rst_o, 1'b0);

    // expire, then supply drop clears it
    tick(WDT + 5);
    check("R6 expired again", wdt_no, 1'b0);
    supply = 1'b0;
    tick(2);
    supply = 1'b1; #1;
    check("R9 recovered", wdt_no, 1'b1);

    // mixed stimulus
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 6)       kick = ~kick;
      else if (r < 8)  mr = ~mr;
      else if (r == 8) supply = ~supply;
      else if (r < 14) pf = ~pf;
      if (supply == 1'b0 && $urandom_range(0, 9) == 0) supply = 1'b1;
      tick(1);
    end

    finish_run();
  end
endmodule